// File: doc/BRIEF.md
# DDS tuning word calculator

This block turns a requested synthesizer output frequency into the phase-increment word that a direct digital synthesizer accumulates every reference clock. In divide mode it takes the output frequency and the reference frequency, both in hertz, and returns floor(2^48 × fout / fref). It gets there with a restoring long divider that produces one quotient bit per clock. The divider brings in the 48 zero bits of the scaling shift itself, after the fout bits, so the caller never forms the 80-bit dividend. The trial subtraction is built from a chain of narrow limbs, and the borrow ripples from one limb to the next.

In multiply mode the reference is fixed. The caller supplies a scale constant equal to 2^80 / fref, which is 2^48 / fref with 32 fractional bits. The block forms the word as fout × scale, keeps the integer part and discards the fraction, using one shift-and-add step per fout bit. In both modes a request is launched with a single-cycle `start`. `busy` covers the whole computation, and `done` pulses once when `word` and the two error flags become valid. Those outputs then hold until the next accepted request.

The controller has four states. IDLE waits for a request. DIV runs the divide steps and MUL runs the multiply steps. FIN is the single cycle in which `done` is high. The transitions are:
- IDLE→DIV on start in divide mode with valid operands.
- IDLE→MUL on start in multiply mode.
- IDLE→FIN on start in divide mode with bad operands.
- DIV→FIN after the last divide step.
- MUL→FIN after the last multiply step.
- FIN→IDLE unconditionally.

Top module: `dds_tw_calc`

## Requirements
- R1: With `mode`=0 (divide) and 0 < fref, fout < fref, the final `word` equals floor(2^48 × fout_hz / fref_hz) and both error flags are 0; for fref=100000000 and fout=11300000 the word is 0x1CED916872B0.
- R2: In divide mode with valid operands, `done` is high after the 81st rising edge, counting the edge that samples `start` as the first (one acceptance edge plus fout-width + 48 = 80 step edges).
- R3: With `mode`=1 (multiply), `word` equals bits [79:32] of fout_hz × scale_k whenever bits [95:80] of that product are zero, and `done` is high after the 33rd rising edge counting the acceptance edge.
- R4: `done` is high for exactly one cycle per request, and `word`, `err_zero` and `err_range` keep their values from the `done` cycle until the next accepted `start`.
- R5: `start` is ignored whenever `busy` is high (including the `done` cycle), and the operands and mode are captured only on the accepting edge, so later changes have no effect on the result.
- R6: In divide mode with fref_hz = 0, `err_zero` is 1, `err_range` is 0, `word` is all ones, and `done` is high after the acceptance edge itself.
- R7: In divide mode with fref_hz ≠ 0 and fout_hz ≥ fref_hz, `err_range` is 1, `err_zero` is 0, `word` is all ones, and `done` is high after the acceptance edge itself.
- R8: In multiply mode, if bits [95:80] of fout_hz × scale_k are not all zero, `err_range` is 1 and `word` is all ones.
- R9: While `rst_n` is low, `busy`, `done`, `word`, `err_zero` and `err_range` are all 0, including when reset arrives in the middle of a computation.
- R10: In multiply mode `fref_hz` has no effect: a zero reference raises no `err_zero`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled in IDLE only |
| mode | input | 1 | 0 = divide by reference, 1 = multiply by scale constant |
| fout_hz | input | 32 | Requested output frequency in Hz |
| fref_hz | input | 32 | Reference clock frequency in Hz (divide mode) |
| scale_k | input | 64 | 2^48/fref with 32 fractional bits (multiply mode) |
| busy | output | 1 | High from the accepting edge until the end of the done cycle |
| done | output | 1 | One-cycle completion pulse |
| word | output | 48 | Phase-increment word |
| err_zero | output | 1 | Divide request had a zero reference |
| err_range | output | 1 | Divide request had fout ≥ fref, or the multiply result overflowed 48 bits |

## Verification
The properties assume that `start` and `mode` are always driven to 0 or 1 and that reset is not released in the middle of a request the checker is tracking. The bench keeps to this: it drives every input at the falling edge and holds `start` low whenever it samples a finished result. In some runs it deliberately keeps `start` high and scrambles the operands while `busy` is set. This lets the latency and hold properties see requests that overlap the busy window, and the result still has to match the operands captured at acceptance. The divide operand pairs stay below 2^32, and they include the boundary cases fout = fref - 1, fout = fref and fout = 0. The multiply constants are picked so that the product lands exactly on the 48-bit limit in one case and one step past it in another.

// File: rtl/dds_tw_pkg.sv
package dds_tw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_MUL  = 2'd2,
        ST_FIN  = 2'd3
    } tw_state_e;

    localparam logic MODE_DIV = 1'b0;
    localparam logic MODE_MUL = 1'b1;

endpackage

// File: rtl/dds_tw_limb_sub.sv
// Multi-limb subtractor: a - b with the borrow rippled limb to limb.
module dds_tw_limb_sub #(
    parameter int W      = 32,
    parameter int LIMB_W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] diff,
    output logic         borrow
);
    localparam int NL = (W + LIMB_W - 1) / LIMB_W;

    logic [NL:0] bc;

    assign bc[0] = 1'b0;

    for (genvar i = 0; i < NL; i++) begin : g_limb
        localparam int LO = i * LIMB_W;
        localparam int WI = ((W - LO) < LIMB_W) ? (W - LO) : LIMB_W;
        logic [WI:0] t;
        assign t = {1'b0, a[LO +: WI]} - {1'b0, b[LO +: WI]} - (WI+1)'(bc[i]);
        assign diff[LO +: WI] = t[WI-1:0];
        assign bc[i+1] = t[WI];
    end

    assign borrow = bc[NL];
endmodule

// File: rtl/dds_tw_div_step.sv
// One restoring division step: shift in a dividend bit, try the subtraction.
module dds_tw_div_step #(
    parameter int FCLK_W = 32,
    parameter int LIMB_W = 8
) (
    input  logic [FCLK_W-1:0] rem_in,
    input  logic              bit_in,
    input  logic [FCLK_W-1:0] divisor,
    output logic [FCLK_W-1:0] rem_out,
    output logic              qbit
);
    logic [FCLK_W:0]   shifted;
    logic [FCLK_W-1:0] diff;
    logic              borrow;

    assign shifted = {rem_in, bit_in};

    dds_tw_limb_sub #(
        .W      (FCLK_W),
        .LIMB_W (LIMB_W)
    ) u_sub (
        .a      (shifted[FCLK_W-1:0]),
        .b      (divisor),
        .diff   (diff),
        .borrow (borrow)
    );

    // A set top bit means the partial remainder already exceeds any divisor.
    assign qbit    = shifted[FCLK_W] | ~borrow;
    assign rem_out = qbit ? diff : shifted[FCLK_W-1:0];
endmodule

// File: rtl/dds_tw_mul_step.sv
// One LSB-first shift-and-add step; the dropped bit is the discarded fraction.
module dds_tw_mul_step #(
    parameter int K_W = 64
) (
    input  logic [K_W-1:0] acc_in,
    input  logic           bit_in,
    input  logic [K_W-1:0] mcand,
    output logic [K_W-1:0] acc_out
);
    logic [K_W:0] sum;

    assign sum     = {1'b0, acc_in} + (bit_in ? {1'b0, mcand} : '0);
    assign acc_out = K_W'(sum >> 1);
endmodule

// File: rtl/dds_tw_calc.sv
module dds_tw_calc
    import dds_tw_pkg::*;
#(
    parameter int FOUT_W  = 32,
    parameter int FCLK_W  = 32,
    parameter int SHIFT_W = 48,
    parameter int K_W     = 64,
    parameter int LIMB_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode,
    input  logic [FOUT_W-1:0]  fout_hz,
    input  logic [FCLK_W-1:0]  fref_hz,
    input  logic [K_W-1:0]     scale_k,
    output logic               busy,
    output logic               done,
    output logic [SHIFT_W-1:0] word,
    output logic               err_zero,
    output logic               err_range
);
    localparam int DIV_STEPS = FOUT_W + SHIFT_W;
    localparam int MUL_STEPS = FOUT_W;
    localparam int CNT_W     = $clog2(DIV_STEPS + 1);
    localparam int CMP_W     = (FOUT_W > FCLK_W) ? FOUT_W : FCLK_W;
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_STEPS - 1);
    localparam logic [CNT_W-1:0] MUL_LAST = CNT_W'(MUL_STEPS - 1);

    tw_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [FOUT_W-1:0]  opa_q;
    logic [FCLK_W-1:0]  fref_q;
    logic [FCLK_W-1:0]  rem_q, rem_d;
    logic [K_W-1:0]     k_q, acc_q, acc_d;
    logic [SHIFT_W-1:0] word_q;
    logic               ez_q, er_q;
    logic               qbit;
    logic               accept, ref_zero, fout_big, bad_div;
    logic               div_last, mul_last;

    assign accept   = (state_q == ST_IDLE) && start;
    assign ref_zero = (fref_hz == '0);
    assign fout_big = (CMP_W'(fout_hz) >= CMP_W'(fref_hz));
    assign bad_div  = ref_zero | fout_big;
    assign div_last = (cnt_q == DIV_LAST);
    assign mul_last = (cnt_q == MUL_LAST);

    dds_tw_div_step #(
        .FCLK_W (FCLK_W),
        .LIMB_W (LIMB_W)
    ) u_div (
        .rem_in  (rem_q),
        .bit_in  (opa_q[FOUT_W-1]),
        .divisor (fref_q),
        .rem_out (rem_d),
        .qbit    (qbit)
    );

    dds_tw_mul_step #(
        .K_W (K_W)
    ) u_mul (
        .acc_in  (acc_q),
        .bit_in  (opa_q[0]),
        .mcand   (k_q),
        .acc_out (acc_d)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (mode == MODE_MUL) state_d = ST_MUL;
                    else if (bad_div)     state_d = ST_FIN;
                    else                  state_d = ST_DIV;
                end
            end
            ST_DIV:  if (div_last) state_d = ST_FIN;
            ST_MUL:  if (mul_last) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Handshake outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin busy = 1'b0; done = 1'b0; end
            ST_DIV:  begin busy = 1'b1; done = 1'b0; end
            ST_MUL:  begin busy = 1'b1; done = 1'b0; end
            ST_FIN:  begin busy = 1'b1; done = 1'b1; end
            default: begin busy = 1'b0; done = 1'b0; end
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            opa_q  <= '0;
            fref_q <= '0;
            rem_q  <= '0;
            k_q    <= '0;
            acc_q  <= '0;
            word_q <= '0;
            ez_q   <= 1'b0;
            er_q   <= 1'b0;
        end else if (accept) begin
            cnt_q  <= '0;
            opa_q  <= fout_hz;
            fref_q <= fref_hz;
            rem_q  <= '0;
            k_q    <= scale_k;
            acc_q  <= '0;
            ez_q   <= 1'b0;
            er_q   <= 1'b0;
            if (mode == MODE_DIV) begin
                if (ref_zero) begin
                    ez_q   <= 1'b1;
                    word_q <= '1;
                end else if (fout_big) begin
                    er_q   <= 1'b1;
                    word_q <= '1;
                end
            end
        end else begin
            unique case (state_q)
                ST_DIV: begin
                    cnt_q  <= cnt_q + 1'b1;
                    rem_q  <= rem_d;
                    opa_q  <= opa_q << 1;
                    word_q <= {word_q[SHIFT_W-2:0], qbit};
                end
                ST_MUL: begin
                    cnt_q <= cnt_q + 1'b1;
                    acc_q <= acc_d;
                    opa_q <= opa_q >> 1;
                    if (mul_last) begin
                        if (|acc_d[K_W-1:SHIFT_W]) begin
                            er_q   <= 1'b1;
                            word_q <= '1;
                        end else begin
                            word_q <= acc_d[SHIFT_W-1:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign word      = word_q;
    assign err_zero  = ez_q;
    assign err_range = er_q;
endmodule

// File: rtl/dds_tw_calc_chk.sv
module dds_tw_calc_chk #(
    parameter int FOUT_W  = 32,
    parameter int SHIFT_W = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               mode,
    input logic               busy,
    input logic               done,
    input logic [SHIFT_W-1:0] word,
    input logic               err_zero,
    input logic               err_range
);
    logic run_q;
    logic mode_q;
    int   cnt_q;
    int   exp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= 1'b0;
            cnt_q  <= 0;
        end else if (start && !busy) begin
            run_q  <= 1'b1;
            mode_q <= mode;
            cnt_q  <= 0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1;
            if (done) run_q <= 1'b0;
        end
    end

    always_comb begin
        if (!mode_q && (err_zero || err_range)) exp_cnt = 0;
        else if (mode_q)                        exp_cnt = FOUT_W;
        else                                    exp_cnt = FOUT_W + SHIFT_W;
    end

    // R2 R3 R6 R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && run_q) |-> (cnt_q == exp_cnt));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(word) && $stable(err_zero) && $stable(err_range)));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6
    zero_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_zero |-> (&word));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_zero && err_range));

    // R10
    mul_no_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && run_q && mode_q) |-> !err_zero);
endmodule

bind dds_tw_calc dds_tw_calc_chk #(
    .FOUT_W  (FOUT_W),
    .SHIFT_W (SHIFT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .busy      (busy),
    .done      (done),
    .word      (word),
    .err_zero  (err_zero),
    .err_range (err_range)
);

// File: tb/dds_tw_calc_tb.sv
`timescale 1ns/1ps
module dds_tw_calc_tb;
    localparam int NV = 14;
    localparam logic [63:0] K_REF = 64'((129'd1 << 80) / 129'd100000000);

    // {mode, fout, fref, scale}
    localparam logic [128:0] VEC [NV] = '{
        {1'b0, 32'd11300000, 32'd100000000, 64'd0},
        {1'b0, 32'd1,        32'd100000000, 64'd0},
        {1'b0, 32'd99999999, 32'd100000000, 64'd0},
        {1'b0, 32'd0,        32'd5,         64'd0},
        {1'b0, 32'd1,        32'd3,         64'd0},
        {1'b0, 32'hFFFFFFFE, 32'hFFFFFFFF,  64'd0},
        {1'b0, 32'd5,        32'd0,         64'd0},
        {1'b0, 32'd7,        32'd7,         64'd0},
        {1'b0, 32'd8,        32'd7,         64'd0},
        {1'b1, 32'd11300000, 32'd0,         K_REF},
        {1'b1, 32'hFFFFFFFF, 32'd0,         64'h0000_0001_0000_0000},
        {1'b1, 32'd12345,    32'd0,         64'h0000_0123_4567_89AB},
        {1'b1, 32'd65536,    32'd0,         64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 32'd65537,    32'd0,         64'hFFFF_FFFF_FFFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        mode;
    logic [31:0] fout_hz;
    logic [31:0] fref_hz;
    logic [63:0] scale_k;
    logic        busy;
    logic        done;
    logic [47:0] word;
    logic        err_zero;
    logic        err_range;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    dds_tw_calc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .fout_hz   (fout_hz),
        .fref_hz   (fref_hz),
        .scale_k   (scale_k),
        .busy      (busy),
        .done      (done),
        .word      (word),
        .err_zero  (err_zero),
        .err_range (err_range)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input logic m, input logic [31:0] fo, input logic [31:0] fr,
                                  input logic [63:0] k, output logic [47:0] w,
                                  output logic ez, output logic er, output int lat);
        logic [127:0] q;
        logic [127:0] p;
        ez = 1'b0;
        er = 1'b0;
        if (!m) begin
            lat = 1;
            if (fr == 0) begin
                ez = 1'b1; w = '1;
            end else if (fo >= fr) begin
                er = 1'b1; w = '1;
            end else begin
                q   = ({96'd0, fo} << 48) / {96'd0, fr};
                w   = q[47:0];
                lat = 81;
            end
        end else begin
            p   = ({64'd0, fo} * {64'd0, k}) >> 32;
            lat = 33;
            if (p[127:48] != 0) begin
                er = 1'b1; w = '1;
            end else begin
                w = p[47:0];
            end
        end
    endfunction

    task automatic run(input logic m, input logic [31:0] fo, input logic [31:0] fr,
                       input logic [63:0] k, input bit noisy, output int lat);
        @(negedge clk);
        mode = m; fout_hz = fo; fref_hz = fr; scale_k = k; start = 1'b1;
        lat = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (noisy) begin
                start = 1'b1; mode = ~m; fout_hz = ~fo; fref_hz = fr ^ 32'h5; scale_k = ~k;
            end else begin
                start = 1'b0;
            end
            if (done || lat > 2000) begin
                start = 1'b0;
                break;
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [47:0] ew;
        logic        eez, eer;
        int          elat, lat;
        logic [47:0] held;
        string       tw, tl;

        rst_n = 1'b0; start = 1'b0; mode = 1'b0;
        fout_hz = '0; fref_hz = '0; scale_k = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 busy", 128'(busy), 128'(0));
        check("R9 done", 128'(done), 128'(0));
        check("R9 word", 128'(word), 128'(0));
        check("R9 flags", 128'({err_zero, err_range}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [128:0] v;
            bit noisy;
            v = VEC[i];
            noisy = (i % 3 == 1);
            model(v[128], v[127:96], v[95:64], v[63:0], ew, eez, eer, elat);
            run(v[128], v[127:96], v[95:64], v[63:0], noisy, lat);
            if (v[128]) begin
                tw = eer ? "R8" : "R3";
                tl = "R3";
            end else begin
                tw = eez ? "R6" : (eer ? "R7" : "R1");
                tl = (eez || eer) ? "R6_R7" : "R2";
            end
            check({tl, " latency"}, 128'(lat), 128'(elat));
            check({tw, " word"}, 128'(word), 128'(ew));
            check({tw, " err_zero"}, 128'(err_zero), 128'(eez));
            check({tw, " err_range"}, 128'(err_range), 128'(eer));
            if (noisy) check("R5 result unaffected by start while busy", 128'(word), 128'(ew));
            if (v[128]) check("R10 no zero flag in multiply mode", 128'(err_zero), 128'(0));
            if (i == 0) check("R1 reference word", 128'(word), 128'(48'h1CED916872B0));
            held = word;
            fout_hz = 32'h1234; fref_hz = 32'h0;
            @(negedge clk);
            check("R4 done one cycle", 128'(done), 128'(0));
            check("R4 busy released", 128'(busy), 128'(0));
            repeat (3) @(negedge clk);
            check("R4 word held", 128'(word), 128'(held));
            check("R4 flags held", 128'({err_zero, err_range}), 128'({eez, eer}));
        end

        // R9 reset in the middle of a computation
        @(negedge clk);
        mode = 1'b0; fout_hz = 32'd3; fref_hz = 32'd10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check("R5 busy during divide", 128'(busy), 128'(1));
        rst_n = 1'b0;
        #1;
        check("R9 busy after mid-run reset", 128'(busy), 128'(0));
        check("R9 word after mid-run reset", 128'(word), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle after release", 128'({busy, done}), 128'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule